// File: doc/BRIEF.md
# BCD Calendar Clock with Selectable 12/24-Hour Hours

This block keeps wall-clock time and date in seven packed-BCD byte registers. A one-second tick from an external divider advances them: seconds, minutes, hours, day of week, day of month, month and a two-digit year that stands for 2000 to 2099. The hour byte selects its own encoding. It counts either 00 to 23, or 1 to 12 with a PM flag. Day-of-month rollover follows the length of each month, and February gets 29 days in leap years.

A byte-wide register port serves the serial bus front end. A command byte opens a transaction. Its bit 7 selects write (1) or read (0), and bits 6:0 give the start address. Data strobes that follow step through the registers. Reads come from a snapshot taken when the command byte arrives, so the bytes of one read always belong to a single instant. Ticks that arrive while a write transaction is open are held back and applied once the transaction closes, so a half-written time is never advanced. A level input from the control logic stops the clock. A one-cycle pulse marks each applied update, so an alarm comparator can test the new time.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the time reads 00:00:00 in 24-hour form, day of week 01, date 01/01, year 00; `rd_data` and `tick_done` are 0.
- R2: Each applied tick adds one to the seconds. Seconds and minutes count 00 to 59 in BCD, and rolling from 59 to 00 carries into the next field.
- R3: With hour bit 6 clear, the hour counts 00 to 23 in BCD. Rolling from 23 to 00 carries into day of week and day of month.
- R4: With hour bit 6 set, bits 4:0 hold the BCD hour 1 to 12 and bit 5 flags PM. The sequence is 12 → 1 → … → 11 → 12, and the PM bit flips on the 11 → 12 step. A day carry is produced only on the step from 11 PM to 12 AM. Bit 6 is never changed by counting.
- R5: Day of month wraps to 01 after 31 (months 01, 03, 05, 07, 08, 10, 12), after 30 (04, 06, 09, 11), and after 28 in February, or after 29 when the year is divisible by 4.
- R6: Day of week counts 1 to 7 and wraps to 1. Month counts 01 to 12 and wraps to 01 with a carry into the year. The year wraps from 99 to 00.
- R7: While `osc_off` is high, ticks are discarded and the time does not change.
- R8: In a write transaction, each `wr_stb` stores `wr_data` at the current address (0 = seconds … 6 = year) and then steps the address, with 6 followed by 0. Unused bits are stored as 0, using the keep masks 7F, 7F, 7F, 07, 3F, 1F, FF for addresses 0 to 6.
- R9: A tick that arrives while a write transaction is open does not change the time. Exactly one increment is applied within two cycles after `cs` falls.
- R10: In a read transaction, each `rd_stb` returns, one cycle later on `rd_data`, the register value as it stood when the command byte arrived, and then steps the address, with 6 followed by 0.
- R11: A start address of 7 or more selects nothing: reads return 00 and writes leave the time unchanged.
- R12: `tick_done` is high for exactly the cycle after an applied tick, and the updated time is visible in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse, once per second |
| osc_off | input | 1 | High stops timekeeping |
| cs | input | 1 | Transaction open (bus chip select, active high) |
| cmd_stb | input | 1 | Command byte valid |
| cmd_byte | input | 8 | Bit 7 write/read, bits 6:0 start address |
| wr_stb | input | 1 | Write data byte valid |
| wr_data | input | 8 | Write data byte |
| rd_stb | input | 1 | Read data byte request |
| rd_data | output | 8 | Registered read data |
| tick_done | output | 1 | Pulse after each applied time update |
| time_flat | output | 56 | Live registers, byte i at bits 8i+7:8i |

## Verification
The assertions assume the loaded values are legal BCD within each field's range, because counting from an illegal value is not defined here. They also assume that strobes arrive only while `cs` is high, with at most one data strobe per cycle, and that no more than one tick is held back during any single write transaction. The stimulus loads only calendar-valid times through complete seven-byte bursts. It drives each strobe for one cycle inside an open transaction and keeps every held write window far shorter than the spacing between ticks. The one deliberately out-of-range byte, used for the keep-mask check, is read back over the bus and never counted.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;
  localparam int NREG     = 7;
  localparam int HOUR_IDX = 2;

  typedef enum logic [1:0] {BUS_IDLE, BUS_RD, BUS_WR} bus_mode_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] b);
    if (b[3:0] == 4'h9) return {b[7:4] + 4'h1, 4'h0};
    return {b[7:4], b[3:0] + 4'h1};
  endfunction

  // Keep masks for stored bits per address.
  function automatic logic [7:0] keep_mask(input int idx);
    case (idx)
      0, 1, 2: return 8'h7F;
      3:       return 8'h07;
      4:       return 8'h3F;
      5:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] floor_val(input int idx);
    return (idx == 3 || idx == 4 || idx == 5) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [7:0] fixed_top(input int idx);
    case (idx)
      0, 1:    return 8'h59;
      3:       return 8'h07;
      5:       return 8'h12;
      default: return 8'h99;
    endcase
  endfunction

  function automatic logic leap_year(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
    return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
  endfunction

  function automatic logic [7:0] month_top(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/bcd_rtc_field.sv
module bcd_rtc_field
  import bcd_rtc_pkg::*;
#(
  parameter logic [7:0] LO    = 8'h00,
  parameter logic [7:0] RSTV  = 8'h00,
  parameter logic [7:0] WMASK = 8'hFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inc,
  input  logic       ld,
  input  logic [7:0] ld_val,
  input  logic [7:0] hi,
  output logic [7:0] val,
  output logic       wrap
);
  logic at_top;
  assign at_top = (val >= hi);
  assign wrap   = inc && at_top;

  always_ff @(posedge clk) begin
    if (rst)      val <= RSTV;
    else if (ld)  val <= ld_val & WMASK;
    else if (inc) val <= at_top ? LO : bcd_inc(val);
  end

  // R2
  wrap_to_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && val == hi) |=> (val == LO));
endmodule

// File: rtl/bcd_rtc_hour.sv
module bcd_rtc_hour
  import bcd_rtc_pkg::*;
#(
  parameter logic [7:0] WMASK = 8'h7F
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inc,
  input  logic       ld,
  input  logic [7:0] ld_val,
  output logic [7:0] val,
  output logic       day_carry
);
  logic       mode12, pm;
  logic [7:0] f24;
  logic [7:0] f12;
  logic [7:0] nxt;

  assign mode12 = val[6];
  assign pm     = val[5];
  assign f24    = {2'b00, val[5:0]};
  assign f12    = {3'b000, val[4:0]};

  always_comb begin
    nxt       = val;
    day_carry = 1'b0;
    if (!mode12) begin
      if (f24 >= 8'h23) begin
        nxt       = 8'h00;
        day_carry = inc;
      end else begin
        nxt = bcd_inc(f24);
      end
    end else begin
      if (f12 == 8'h11) begin
        nxt       = {1'b0, 1'b1, ~pm, 5'h12};
        day_carry = inc && pm;
      end else if (f12 >= 8'h12) begin
        nxt = {1'b0, 1'b1, pm, 5'h01};
      end else begin
        nxt = {1'b0, 1'b1, pm, bcd_inc(f12)[4:0]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      val <= 8'h00;
    else if (ld)  val <= ld_val & WMASK;
    else if (inc) val <= nxt;
  end

  // R3
  roll24_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && !val[6] && val == 8'h23) |=> (val == 8'h00));
  // R4
  pm_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && val[6] && val[4:0] == 5'h11) |=> (val[5] != $past(val[5]) && val[4:0] == 5'h12));
  // R4
  mode_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld) |=> (val[6] == $past(val[6])));
endmodule

// File: rtl/bcd_rtc_bus.sv
module bcd_rtc_bus
  import bcd_rtc_pkg::*;
#(
  parameter int N  = NREG,
  parameter int AW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs,
  input  logic           cmd_stb,
  input  logic [7:0]     cmd_byte,
  input  logic           wr_stb,
  input  logic           rd_stb,
  input  logic           tick_in,
  input  logic [N*8-1:0] live,
  output logic [N-1:0]   ld_vec,
  output logic [7:0]     rd_data,
  output logic           tick_eff
);
  bus_mode_t   mode;
  logic [AW-1:0] ptr;
  logic        ptr_ok;
  logic        pending;
  logic        hold;
  logic        step;
  logic [7:0]  snap [N];
  logic [AW-1:0] ptr_nx;

  assign hold     = (mode == BUS_WR);
  assign tick_eff = !hold && (tick_in || pending);
  assign ptr_nx   = (ptr == AW'(N - 1)) ? '0 : ptr + 1'b1;
  assign step     = cs && !cmd_stb && ptr_ok &&
                    ((wr_stb && mode == BUS_WR) || (rd_stb && mode == BUS_RD));

  always_comb begin
    ld_vec = '0;
    if (cs && !cmd_stb && wr_stb && mode == BUS_WR && ptr_ok)
      ld_vec[ptr] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= BUS_IDLE;
      ptr     <= '0;
      ptr_ok  <= 1'b0;
      pending <= 1'b0;
      rd_data <= 8'h00;
    end else begin
      pending <= hold ? (pending || tick_in) : (pending && tick_in);
      if (!cs) begin
        mode <= BUS_IDLE;
      end else if (cmd_stb) begin
        mode   <= cmd_byte[7] ? BUS_WR : BUS_RD;
        ptr    <= cmd_byte[AW-1:0];
        ptr_ok <= (int'(cmd_byte[6:0]) < N);
      end else begin
        if (rd_stb)
          rd_data <= (mode == BUS_RD && ptr_ok) ? snap[ptr] : 8'h00;
        if (step) ptr <= ptr_nx;
      end
    end
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_snap
      always_ff @(posedge clk) begin
        if (rst) snap[i] <= 8'h00;
        else if (cs && cmd_stb && !cmd_byte[7]) snap[i] <= live[i*8 +: 8];
      end
    end
  endgenerate

  // R9
  held_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && tick_in) |=> pending);
  // R8
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (step && ptr == AW'(N - 1)) |=> (ptr == '0));
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import bcd_rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        osc_off,
  input  logic        cs,
  input  logic        cmd_stb,
  input  logic [7:0]  cmd_byte,
  input  logic        wr_stb,
  input  logic [7:0]  wr_data,
  input  logic        rd_stb,
  output logic [7:0]  rd_data,
  output logic        tick_done,
  output logic [55:0] time_flat
);
  localparam int N = NREG;

  logic [N-1:0] ld_vec;
  logic         tick_eff;
  logic         tick_in;
  logic [7:0]   val_v [N];
  logic [7:0]   hi_v  [N];
  logic [N-1:0] inc_v;
  logic [N-1:0] wrap_v;
  logic         day_carry;

  assign tick_in = tick && !osc_off;

  bcd_rtc_bus #(.N(N)) u_bus (
    .clk(clk), .rst(rst), .cs(cs), .cmd_stb(cmd_stb), .cmd_byte(cmd_byte),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .tick_in(tick_in), .live(time_flat),
    .ld_vec(ld_vec), .rd_data(rd_data), .tick_eff(tick_eff)
  );

  // Carry ripple: sec -> min -> hour -> (dow, mday) -> mon -> year
  assign inc_v[0] = tick_eff;
  assign inc_v[1] = wrap_v[0];
  assign inc_v[2] = wrap_v[1];
  assign inc_v[3] = day_carry;
  assign inc_v[4] = day_carry;
  assign inc_v[5] = wrap_v[4];
  assign inc_v[6] = wrap_v[5];

  generate
    for (genvar i = 0; i < N; i++) begin : g_fld
      assign time_flat[i*8 +: 8] = val_v[i];
      if (i == HOUR_IDX) begin : g_hour
        assign hi_v[i]   = 8'h00;
        assign wrap_v[i] = day_carry;
        bcd_rtc_hour #(.WMASK(keep_mask(i))) u_hour (
          .clk(clk), .rst(rst), .inc(inc_v[i]), .ld(ld_vec[i]),
          .ld_val(wr_data), .val(val_v[i]), .day_carry(day_carry)
        );
      end else begin : g_plain
        if (i == 4) begin : g_mday
          assign hi_v[i] = month_top(val_v[5], val_v[6]);
        end else begin : g_fixed
          assign hi_v[i] = fixed_top(i);
        end
        bcd_rtc_field #(
          .LO(floor_val(i)), .RSTV(floor_val(i)), .WMASK(keep_mask(i))
        ) u_fld (
          .clk(clk), .rst(rst), .inc(inc_v[i]), .ld(ld_vec[i]),
          .ld_val(wr_data), .hi(hi_v[i]), .val(val_v[i]), .wrap(wrap_v[i])
        );
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) tick_done <= 1'b0;
    else     tick_done <= tick_eff;
  end

  // R12
  done_follows_chk: assert property (@(posedge clk) disable iff (rst)
    tick_eff |=> tick_done);
  // R7
  still_time_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_eff && ld_vec == '0) |=> $stable(time_flat));
endmodule

// File: tb/bcd_rtc_core_test.sv
module bcd_rtc_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, osc_off = 1'b0, cs = 1'b0, cmd_stb = 1'b0;
  logic [7:0]  cmd_byte = 8'h00, wr_data = 8'h00;
  logic        wr_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0]  rd_data;
  logic        tick_done;
  logic [55:0] time_flat;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bcd_rtc_core uut (
    .clk(clk), .rst(rst), .tick(tick), .osc_off(osc_off), .cs(cs),
    .cmd_stb(cmd_stb), .cmd_byte(cmd_byte), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_stb(rd_stb), .rd_data(rd_data), .tick_done(tick_done), .time_flat(time_flat)
  );

  // {preload, expected after one tick}; bytes year..sec, msb first
  localparam logic [111:0] VEC [20] = '{
    {56'h00_01_01_01_00_00_00, 56'h00_01_01_01_00_00_01},
    {56'h00_01_01_01_00_00_59, 56'h00_01_01_01_00_01_00},
    {56'h99_12_31_07_23_59_59, 56'h00_01_01_01_00_00_00},
    {56'h24_05_10_03_09_59_59, 56'h24_05_10_03_10_00_00},
    {56'h23_02_28_02_23_59_59, 56'h23_03_01_03_00_00_00},
    {56'h24_02_28_02_23_59_59, 56'h24_02_29_03_00_00_00},
    {56'h24_02_29_05_23_59_59, 56'h24_03_01_06_00_00_00},
    {56'h25_04_30_01_23_59_59, 56'h25_05_01_02_00_00_00},
    {56'h25_01_31_04_23_59_59, 56'h25_02_01_05_00_00_00},
    {56'h25_04_29_01_23_59_59, 56'h25_04_30_02_00_00_00},
    {56'h25_06_15_03_51_59_59, 56'h25_06_15_03_72_00_00},
    {56'h25_06_15_03_71_59_59, 56'h25_06_16_04_52_00_00},
    {56'h25_06_15_03_52_59_59, 56'h25_06_15_03_41_00_00},
    {56'h25_06_15_03_72_59_59, 56'h25_06_15_03_61_00_00},
    {56'h25_06_15_03_69_59_59, 56'h25_06_15_03_70_00_00},
    {56'h00_02_28_06_23_59_59, 56'h00_02_29_07_00_00_00},
    {56'h19_02_28_07_23_59_59, 56'h19_03_01_01_00_00_00},
    {56'h12_02_28_01_23_59_59, 56'h12_02_29_02_00_00_00},
    {56'h25_09_30_02_23_59_59, 56'h25_10_01_03_00_00_00},
    {56'h25_11_30_02_23_59_59, 56'h25_12_01_03_00_00_00}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic load_time(input logic [55:0] t);
    cs = 1'b1; cmd_stb = 1'b1; cmd_byte = 8'h80;
    cyc(1);
    cmd_stb = 1'b0;
    for (int i = 0; i < 7; i++) begin
      wr_stb = 1'b1; wr_data = t[i*8 +: 8];
      cyc(1);
    end
    wr_stb = 1'b0; cs = 1'b0;
    cyc(2);
  endtask

  task automatic one_tick();
    tick = 1'b1;
    cyc(1);
    tick = 1'b0;
  endtask

  task automatic read_one(input logic [7:0] addr, output logic [7:0] v);
    cs = 1'b1; cmd_stb = 1'b1; cmd_byte = addr;
    cyc(1);
    cmd_stb = 1'b0; rd_stb = 1'b1;
    cyc(1);
    v = rd_data;
    rd_stb = 1'b0; cs = 1'b0;
    cyc(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [7:0] r0, r1, r2;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    check("R1", 64'(time_flat), 64'h00_01_01_01_00_00_00);
    check("R1", 64'(rd_data), 64'h0);
    check("R1", 64'(tick_done), 64'h0);

    // R2, R3, R4, R5, R6 vector walk
    for (int v = 0; v < 20; v++) begin
      load_time(VEC[v][111:56]);
      one_tick();
      check("R2,R3,R4,R5,R6", 64'(time_flat), 64'(VEC[v][55:0]));
    end

    // R12 pulse
    load_time(56'h25_03_03_01_10_00_00);
    one_tick();
    check("R12", 64'(tick_done), 64'h1);
    cyc(1);
    check("R12", 64'(tick_done), 64'h0);

    // R7 oscillator stopped
    osc_off = 1'b1;
    one_tick();
    cyc(1);
    osc_off = 1'b0;
    check("R7", 64'(time_flat), 64'h25_03_03_01_10_00_01);

    // R8 keep mask on day of week, read back via bus
    cs = 1'b1; cmd_stb = 1'b1; cmd_byte = 8'h83; cyc(1);
    cmd_stb = 1'b0; wr_stb = 1'b1; wr_data = 8'hFF; cyc(1);
    wr_stb = 1'b0; cs = 1'b0; cyc(2);
    read_one(8'h03, b);
    check("R8", 64'(b), 64'h07);

    // R8 address wrap from year to seconds
    load_time(56'h25_03_03_01_10_00_00);
    cs = 1'b1; cmd_stb = 1'b1; cmd_byte = 8'h86; cyc(1);
    cmd_stb = 1'b0; wr_stb = 1'b1; wr_data = 8'h42; cyc(1);
    wr_data = 8'h05; cyc(1);
    wr_stb = 1'b0; cs = 1'b0; cyc(2);
    check("R8", 64'(time_flat), 64'h42_03_03_01_10_00_05);

    // R11 invalid address
    cs = 1'b1; cmd_stb = 1'b1; cmd_byte = 8'h87; cyc(1);
    cmd_stb = 1'b0; wr_stb = 1'b1; wr_data = 8'h33; cyc(1);
    wr_stb = 1'b0; cs = 1'b0; cyc(2);
    check("R11", 64'(time_flat), 64'h42_03_03_01_10_00_05);
    read_one(8'h07, b);
    check("R11", 64'(b), 64'h00);

    // R9 tick held during write transaction
    load_time(56'h25_01_01_01_00_00_10);
    cs = 1'b1; cmd_stb = 1'b1; cmd_byte = 8'h80; cyc(1);
    cmd_stb = 1'b0; wr_stb = 1'b1; wr_data = 8'h58; cyc(1);
    wr_stb = 1'b0;
    one_tick();
    cyc(1);
    check("R9", 64'(time_flat[7:0]), 64'h58);
    cs = 1'b0;
    cyc(3);
    check("R9", 64'(time_flat[7:0]), 64'h59);

    // R10 snapshot coherent across a tick
    load_time(56'h25_06_15_03_23_59_59);
    cs = 1'b1; cmd_stb = 1'b1; cmd_byte = 8'h00; cyc(1);
    cmd_stb = 1'b0; rd_stb = 1'b1; tick = 1'b1; cyc(1);
    tick = 1'b0; r0 = rd_data; cyc(1);
    r1 = rd_data; cyc(1);
    r2 = rd_data; rd_stb = 1'b0; cs = 1'b0; cyc(1);
    check("R10", 64'({r2, r1, r0}), 64'h23_59_59);
    check("R10", 64'(time_flat), 64'h25_06_16_04_00_00_00);

    // R10 read address wrap 6 -> 0
    cs = 1'b1; cmd_stb = 1'b1; cmd_byte = 8'h06; cyc(1);
    cmd_stb = 1'b0; rd_stb = 1'b1; cyc(1);
    r0 = rd_data; cyc(1);
    r1 = rd_data; rd_stb = 1'b0; cs = 1'b0; cyc(1);
    check("R10", 64'({r0, r1}), 64'h25_00);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule